// File: doc/BRIEF.md
# Fast-Page DRAM Access Controller

This block sits between a processor's bus and an asynchronous DRAM with a multiplexed address bus. It turns each bus request into a sequence of strobes: row strobe, an upper and a lower byte-lane column strobe, write enable and output enable. It places the row and then the column on one shared set of address lines. A small configuration register holds two settings. The first is the multiplex shift size, which sets where the row field begins inside the byte address. The second is a page-mode enable.

With page mode off, each access opens a row and closes it again. With page mode on, the row stays open after an access. A following access whose row field matches then costs only a two-state column cycle. A miss, a request for another bus space, or an idle cycle closes the row. One precharge state always comes before the next row is opened.

A request stays presented until the one-cycle ready pulse. The controller samples a new request in the idle state or the row-open state. That is the cycle after the previous ready, or any later cycle.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, page mode is off, the shift code is 0, the row strobe, both column strobes, write enable and output enable are high, ready is low, and no row is open.
- R2: A full access runs one precharge state, one row state, and two column states. Ready is high in the second column state, four cycles after the sampling cycle. The column, byte address bits [11:1], is on the address lines while a column strobe is low.
- R3: With page mode off, every access is a full access, even when it hits the same row as the one before.
- R4: With page mode on, an access whose row field matches the open row keeps the row strobe low throughout. Ready comes two cycles after the sampling cycle.
- R5: With page mode on, a row miss raises the row strobe for exactly one precharge state before the new row strobe.
- R6: In the row-open state, a cycle with no request raises the row strobe in the next cycle.
- R7: A request with the DRAM-space flag low gets ready one cycle after sampling. It drives no column strobe, no write enable and no output enable, and it closes any open row.
- R8: Shift codes 0, 1, 2 and 3 select shift sizes of 8, 9, 10 and 11. Codes 4 to 7 act as 8. For shift size s, the row field is byte address bits [23:s+1]. The row value on the address lines is the address shifted right by s+1.
- R9: Word accesses assert both column strobes. For byte accesses, address bit 0 = 0 selects the upper lane strobe and bit 0 = 1 selects the lower lane strobe.
- R10: During the column states, a write drives write enable low and the write data with its enable high. A read drives output enable low instead. The two enables are never low together.
- R11: On a read, the data lines are captured at the end of the second column state. They are held on the read-data output until the next read.
- R12: Ready is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads the configuration register |
| cfg_burst | input | 1 | Page-mode enable to load |
| cfg_shift | input | 3 | Multiplex shift code to load |
| req_valid | input | 1 | Request present, held until ready |
| req_dram | input | 1 | Request targets DRAM space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Captured read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Read data from the DRAM |

## Verification
The bench targets the row-compare boundary at each shift size, including a reserved code. A design with the wrong boundary would take a miss for a hit, or a hit for a miss, and so show the wrong latency and row value. Back-to-back accesses check the following:
- A hit never lifts the row strobe; a controller that reopens the row would show extra cycles.
- A miss gives exactly one precharge state.
- A non-DRAM access in between forces the next DRAM access to be a full access.

Byte accesses at even and odd addresses catch swapped lanes. A request gap after a page hit must close the row, which catches a controller that leaves the row strobe low forever.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_OPEN  = 3'd1,
    S_PRE   = 3'd2,
    S_ROW   = 3'd3,
    S_COL1  = 3'd4,
    S_COL2  = 3'd5,
    S_OTHER = 3'd6
  } seq_state_t;

  localparam int SHIFT_CODE_W = 3;
  localparam int SHIFT_W      = 4;

  // shift code -> number of column bits; reserved codes fall back to 8
  function automatic logic [SHIFT_W-1:0] decode_shift(input logic [SHIFT_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    case (code)
      3'd0:    s = 4'd8;
      3'd1:    s = 4'd9;
      3'd2:    s = 4'd10;
      3'd3:    s = 4'd11;
      default: s = 4'd8;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dram_cfg_reg.sv
module dram_cfg_reg
  import dram_page_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    burst_in,
  input  logic [SHIFT_CODE_W-1:0] code_in,
  output logic                    burst_en,
  output logic [SHIFT_W-1:0]      shift_bits
);

  logic                    burst_q, burst_d;
  logic [SHIFT_CODE_W-1:0] code_q,  code_d;

  always_comb begin
    burst_d = burst_q;
    code_d  = code_q;
    if (load) begin
      burst_d = burst_in;
      code_d  = code_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      code_q  <= '0;
    end else begin
      burst_q <= burst_d;
      code_q  <= code_d;
    end
  end

  assign burst_en   = burst_q;
  assign shift_bits = decode_shift(code_q);

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_bits >= 4'd8) && (shift_bits <= 4'd11)) else $error("shift size out of range"); // R8

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(burst_en)) else $error("page enable changed without load"); // R3

endmodule

// File: rtl/dram_row_track.sv
module dram_row_track
  import dram_page_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MA_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SHIFT_W-1:0] shift_bits,
  output logic               row_hit,
  output logic [MA_W-1:0]    row_val,
  output logic [MA_W-1:0]    col_val
);

  localparam int SHAMT_W = SHIFT_W + 1;

  logic [ADDR_W-1:0]  cur_q, cur_d;
  logic [ADDR_W-1:0]  row_mask;
  logic [SHAMT_W-1:0] shamt;

  assign shamt    = {1'b0, shift_bits} + SHAMT_W'(1);
  assign row_mask = {ADDR_W{1'b1}} << shamt;

  always_comb begin
    cur_d = cur_q;
    if (capture) cur_d = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign row_hit = ((req_addr ^ cur_q) & row_mask) == '0;
  assign row_val = MA_W'(cur_q >> shamt);
  assign col_val = cur_q[MA_W:1];

  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> row_hit || !$stable(req_addr)) else $error("captured row does not compare equal"); // R4

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_page_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dram,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_lane,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              burst_en,
  input  logic              row_hit,
  output logic              accept,
  output logic              ready,
  output logic              rd_capture,
  output logic              sel_row,
  output logic              ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);

  seq_state_t        state_q, state_d;
  logic              write_q, word_q, lane_q;
  logic [DATA_W-1:0] wdata_q;
  logic              col_phase, cas_on;

  assign accept = req_valid && ((state_q == S_IDLE) || (state_q == S_OPEN));

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid) state_d = req_dram ? S_PRE : S_OTHER;
      S_OPEN: begin
        if (!req_valid)     state_d = S_IDLE;
        else if (!req_dram) state_d = S_OTHER;
        else if (row_hit)   state_d = S_COL1;
        else                state_d = S_PRE;
      end
      S_PRE:   state_d = S_ROW;
      S_ROW:   state_d = S_COL1;
      S_COL1:  state_d = S_COL2;
      S_COL2:  state_d = burst_en ? S_OPEN : S_IDLE;
      S_OTHER: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      lane_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        write_q <= req_write;
        word_q  <= req_word;
        lane_q  <= req_lane;
        wdata_q <= req_wdata;
      end
    end
  end

  // strobe decode
  assign col_phase  = (state_q == S_COL1) || (state_q == S_COL2);
  assign cas_on     = (state_q == S_COL2);
  assign ras_n      = !((state_q == S_ROW) || col_phase || (state_q == S_OPEN));
  assign ucas_n     = !(cas_on && (word_q || !lane_q));
  assign lcas_n     = !(cas_on && (word_q || lane_q));
  assign we_n       = !(col_phase && write_q);
  assign oe_n       = !(col_phase && !write_q);
  assign dq_oe      = col_phase && write_q;
  assign dq_out     = wdata_q;
  assign sel_row    = !col_phase;
  assign ready      = (state_q == S_COL2) || (state_q == S_OTHER);
  assign rd_capture = cas_on && !write_q;

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucas_n || !lcas_n) |-> !ras_n) else $error("column strobe without row strobe"); // R2
  AST_ROW_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(state_q == S_PRE)) else $error("row opened without precharge"); // R5
  AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OPEN && req_valid && req_dram && row_hit) |=> !ras_n && (state_q == S_COL1)) else $error("hit did not go to column phase"); // R4
  AST_IDLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OPEN && !req_valid) |=> ras_n) else $error("idle row left open"); // R6
  AST_NOPAGE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COL2 && !burst_en) |=> ras_n) else $error("row kept open with page mode off"); // R3
  AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_dram) |=> ras_n && ucas_n && lcas_n && we_n && oe_n) else $error("strobe during non-DRAM access"); // R7
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)) else $error("write and output enable together"); // R10
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready) else $error("ready longer than one cycle"); // R12

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int MA_W   = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_burst,
  input  logic [SHIFT_CODE_W-1:0] cfg_shift,
  input  logic                    req_valid,
  input  logic                    req_dram,
  input  logic                    req_write,
  input  logic                    req_word,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic [DATA_W-1:0]       req_rdata,
  output logic [MA_W-1:0]         dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_ucas_n,
  output logic                    dram_lcas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   burst_en, row_hit, accept, rd_capture, sel_row;
  logic [SHIFT_W-1:0]     shift_bits;
  logic [MA_W-1:0]        row_val, col_val;
  logic [DATA_W-1:0]      rdata_q, rdata_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  dram_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (cfg_load),
    .burst_in   (cfg_burst),
    .code_in    (cfg_shift),
    .burst_en   (burst_en),
    .shift_bits (shift_bits)
  );

  dram_row_track #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_row (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture    (accept),
    .req_addr   (req_addr),
    .shift_bits (shift_bits),
    .row_hit    (row_hit),
    .row_val    (row_val),
    .col_val    (col_val)
  );

  dram_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_dram   (req_dram),
    .req_write  (req_write),
    .req_word   (req_word),
    .req_lane   (req_addr[0]),
    .req_wdata  (req_wdata),
    .burst_en   (burst_en),
    .row_hit    (row_hit),
    .accept     (accept),
    .ready      (req_ready),
    .rd_capture (rd_capture),
    .sel_row    (sel_row),
    .ras_n      (dram_ras_n),
    .ucas_n     (dram_ucas_n),
    .lcas_n     (dram_lcas_n),
    .we_n       (dram_we_n),
    .oe_n       (dram_oe_n),
    .dq_oe      (dram_dq_oe),
    .dq_out     (dram_dq_out)
  );

  assign dram_addr = sel_row ? row_val : col_val;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_capture) rdata_d = dram_dq_in;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign req_rdata = rdata_q;

  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_capture |=> $stable(req_rdata)) else $error("read data changed outside a read"); // R11

endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;

  typedef struct packed {
    logic        dram;
    logic        write;
    logic        word;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [2:0]  base;
    logic        chk_pre;
  } vec_t;

  // page mode on, shift code 2 (10): row field = addr[23:11]
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b1, 24'h001234, 16'h0000, 3'd4, 1'b0},
    '{1'b1, 1'b1, 1'b1, 24'h001236, 16'hBEEF, 3'd2, 1'b0},
    '{1'b1, 1'b1, 1'b0, 24'h001239, 16'h0042, 3'd2, 1'b0},
    '{1'b1, 1'b0, 1'b0, 24'h001238, 16'h0000, 3'd2, 1'b0},
    '{1'b1, 1'b0, 1'b1, 24'h001A00, 16'h0000, 3'd4, 1'b1},
    '{1'b0, 1'b1, 1'b1, 24'h400000, 16'h1111, 3'd1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 24'h001A02, 16'hCAFE, 3'd4, 1'b0},
    '{1'b1, 1'b0, 1'b1, 24'h001A04, 16'h0000, 3'd2, 1'b0}
  };

  logic        clk, rst_n;
  logic        cfg_load, cfg_burst;
  logic [2:0]  cfg_shift;
  logic        req_valid, req_dram, req_write, req_word;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic [15:0] req_rdata;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  int n_tests = 0;
  int n_fail  = 0;
  int shift_now = 8;
  bit b2b = 0;
  bit pend_rd = 0, pend_rdy = 0;
  logic [15:0] pend_val;

  dram_page_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_burst(cfg_burst), .cfg_shift(cfg_shift),
    .req_valid(req_valid), .req_dram(req_dram), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
    .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // DRAM read model: data reflects the address lines
  assign dram_dq_in = {5'h1A, dram_addr};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pending();
    if (pend_rd)  chk(req_rdata == pend_val, "R11", "read data", req_rdata, pend_val);
    if (pend_rdy) chk(!req_ready, "R12", "ready width", req_ready, 0);
    pend_rd = 0; pend_rdy = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    pending();
    b2b = 0;
  endtask

  task automatic set_cfg(input logic burst, input logic [2:0] code);
    tick(); tick();
    cfg_burst = burst; cfg_shift = code; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    shift_now = (code < 3'd4) ? 8 + int'(code) : 8;   // R8 encoding
  endtask

  task automatic run_req(input vec_t v, input string tag);
    int lat = 0, hi = 0, exp_lat;
    bit us = 0, ls = 0, wes = 0, oes = 0, row_got = 0, dqoe_s = 0, prev_ras;
    logic [10:0] row_s = '0, col_s = '0, exp_row, exp_col;
    logic [15:0] dq_s = '0;
    bit exp_u, exp_l;
    exp_lat  = int'(v.base) + (b2b ? 1 : 0);
    prev_ras = dram_ras_n;
    req_valid = 1'b1; req_dram = v.dram; req_write = v.write; req_word = v.word;
    req_addr = v.addr; req_wdata = v.wdata;
    do begin
      @(negedge clk);
      if (lat == 0) pending();
      lat++;
      if (dram_ras_n) hi++;
      if (!dram_ras_n && prev_ras) begin row_got = 1; row_s = dram_addr; end
      prev_ras = dram_ras_n;
      if (!dram_ucas_n) us = 1;
      if (!dram_lcas_n) ls = 1;
      if (!dram_we_n) wes = 1;
      if (!dram_oe_n) oes = 1;
      if (!dram_ucas_n || !dram_lcas_n) begin col_s = dram_addr; dq_s = dram_dq_out; dqoe_s = dram_dq_oe; end
    end while (!req_ready && lat < 20);
    req_valid = 1'b0;
    chk(lat == exp_lat, tag, "latency", lat, exp_lat);
    if (v.dram) begin
      exp_u = v.word || !v.addr[0];            // R9 lane select
      exp_l = v.word || v.addr[0];
      exp_col = v.addr[11:1];
      chk(us == exp_u, "R9", "upper strobe", us, exp_u);
      chk(ls == exp_l, "R9", "lower strobe", ls, exp_l);
      chk(wes == v.write && oes == !v.write, "R10", "we/oe", {wes, oes}, {v.write, !v.write});
      chk(col_s == exp_col, "R2", "column address", col_s, exp_col);
      if (v.write) chk(dqoe_s && dq_s == v.wdata, "R10", "write data", dq_s, v.wdata);
      else begin pend_rd = 1; pend_val = {5'h1A, exp_col}; end
      if (v.base == 3'd4) begin
        exp_row = 11'(v.addr >> (shift_now + 1));
        chk(row_got && row_s == exp_row, "R8", "row address", row_s, exp_row);
      end
      if (v.base == 3'd2) chk(hi == 0, "R4", "row strobe held", hi, 0);
      if (v.chk_pre)      chk(hi == 1, "R5", "precharge states", hi, 1);
    end else begin
      chk(!us && !ls && !wes && !oes, "R7", "no strobes", {us, ls, wes, oes}, 0);
    end
    pend_rdy = 1;
    b2b = 1;
  endtask

  function automatic vec_t mk(input logic wr, input logic [23:0] a, input logic [2:0] base);
    mk = '{1'b1, wr, 1'b1, a, 16'h5A5A, base, 1'b0};
  endfunction

  initial begin
    rst_n = 1'b0; cfg_load = 0; cfg_burst = 0; cfg_shift = 0;
    req_valid = 0; req_dram = 0; req_write = 0; req_word = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: strobes idle in reset and after release
    chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n && !req_ready,
        "R1", "strobes in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, req_ready}, 6'b111110);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n && !req_ready,
        "R1", "strobes after reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, req_ready}, 6'b111110);

    // R1, R3: default is page mode off, shift 8; same-row pair both full
    run_req(mk(1'b0, 24'h000010, 3'd4), "R1");
    run_req(mk(1'b0, 24'h000012, 3'd4), "R3");
    run_req(mk(1'b1, 24'h000014, 3'd4), "R3");

    // table walk: page mode on, shift 10
    set_cfg(1'b1, 3'd2);
    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = (VEC[i].base == 3'd4) ? (VEC[i].chk_pre ? "R5" : "R2") :
           (VEC[i].base == 3'd2) ? "R4" : "R7";
      run_req(VEC[i], tg);
    end

    // R6: no request after a page hit closes the row one cycle later
    tick();
    chk(!dram_ras_n, "R6", "row still open in decision cycle", dram_ras_n, 0);
    tick();
    chk(dram_ras_n, "R6", "row closed after idle", dram_ras_n, 1);

    // R8: shift 11, bit 11 is column side -> hit
    set_cfg(1'b1, 3'd3);
    run_req(mk(1'b0, 24'h000000, 3'd4), "R8");
    run_req(mk(1'b0, 24'h000800, 3'd2), "R8");
    // R8: shift 8, bit 9 is row side -> miss
    set_cfg(1'b1, 3'd0);
    run_req(mk(1'b0, 24'h000000, 3'd4), "R8");
    run_req(mk(1'b0, 24'h000200, 3'd4), "R8");
    // R8: reserved code 7 behaves as 8
    set_cfg(1'b1, 3'd7);
    run_req(mk(1'b0, 24'h000000, 3'd4), "R8");
    run_req(mk(1'b1, 24'h000100, 3'd2), "R8");
    run_req(mk(1'b0, 24'h000200, 3'd4), "R8");
    tick(); tick();
    report();
  end

endmodule